// File: doc/BRIEF.md
# Receive Idle Time-out and Interrupt Prioritizer

This block sits beside a serial receiver and its receive FIFO. It watches how long the line has been quiet while the FIFO still holds characters. Once four whole frame times pass with no new character and no read, it raises a character time-out flag, so software fetches the leftover bytes that never reached the trigger level. The frame time is computed from the live word length, parity and stop-bit settings, and the count runs on the 16x baud tick.

The same block merges every interrupt cause of the serial channel into one request line and a small identifier code. The code names only the most urgent cause that is both pending and enabled. Lower causes stay hidden until the higher ones are cleared. The transmit-empty cause is held in the block itself, because it is consumed by reading the identifier. The other causes arrive as levels from the status logic that owns them.

Top module: `rx_timeout_irq`

## Requirements
- R1: The time-out flag `tout` never rises while `fifo_cnt` is zero, and the idle counter is held at zero while the FIFO is empty.
- R2: A `stop_mid` strobe or an `rhr_rd` strobe restarts the idle count, so the full period must elapse again after the last strobe before `tout` can rise.
- R3: With `baud_tick` high on every cycle, `tout` rises on the Lth rising edge after the restart edge. L = 4 x 16 x (1 start + data bits + parity bit if `parity_en` + stop bits). Data bits are 5, 6, 7 or 8 for `wlen_sel` 0, 1, 2 or 3. Stop bits are 1 when `stop_long`=0, 1.5 when `stop_long`=1 and `wlen_sel`=0, and 2 otherwise.
- R4: `tout` clears on the clock edge that samples `rhr_rd` high.
- R5: Receive data is ready when `fifo_cnt` is nonzero and `fifo_cnt >= rx_trig`. Data-ready and time-out share one level, both gated by `ien[0]`. When `tout` is set, that level reports code 3 (time-out), and otherwise code 2 (data ready).
- R6: Priority from highest to lowest: line status (`line_evt`, `ien[2]`, code 1), then receive data/time-out, then transmit empty (`ien[1]`, code 4), then modem status (`modem_evt`, `ien[3]`, code 5), then CTS/RTS change (`flow_evt`, `ien[4]`, code 6). `iid` shows only the highest pending enabled cause.
- R7: With no enabled cause pending, `iid` is 0 and `irq` is low. Otherwise `irq` is high.
- R8: After reset the transmit-empty cause is already pending. If `ien[1]` and `tx_empty` are high, `iid` reads 4 at once.
- R9: The transmit-empty cause clears on an `iid_rd` strobe while `iid` is 4, or on a `thr_wr` strobe. It comes back on a rising edge of `tx_empty`.
- R10: A cause whose enable bit is low is not reported, and the next lower enabled cause shows through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | 16x baud enable, one per sixteenth of a bit |
| wlen_sel | input | 2 | Data bits select, 0..3 for 5..8 bits |
| parity_en | input | 1 | Parity bit present in the frame |
| stop_long | input | 1 | Long stop (1.5 bits for 5-bit words, else 2) |
| stop_mid | input | 1 | Strobe at the centre of a received stop bit |
| rhr_rd | input | 1 | Receive holding register read strobe |
| fifo_cnt | input | CNT_W | Characters held in the receive FIFO |
| rx_trig | input | CNT_W | Receive trigger level |
| ien | input | 5 | Enables: 0 rx, 1 tx empty, 2 line, 3 modem, 4 CTS/RTS |
| tx_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iid_rd | input | 1 | Identifier read strobe |
| line_evt | input | 1 | Line-status cause pending |
| modem_evt | input | 1 | Modem-status cause pending |
| flow_evt | input | 1 | CTS/RTS change cause pending |
| tout | output | 1 | Character time-out flag |
| irq | output | 1 | Interrupt request |
| iid | output | 3 | Highest pending cause code |

## Verification
The bench builds the block with its defaults: a 32-entry FIFO, 16 ticks per bit, four characters per time-out, the CTS/RTS level included and a combinational identifier. The combinational identifier lets every priority vector be checked in the same cycle that it is applied. The small tick ratio keeps the longest period at a few hundred cycles. That makes it practical to probe the exact rising edge of the time-out for three frame formats, including the 1.5-stop case.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   typedef enum logic [2:0] {
      IID_NONE    = 3'd0,
      IID_LINE    = 3'd1,
      IID_RXDATA  = 3'd2,
      IID_RXTOUT  = 3'd3,
      IID_TXEMPTY = 3'd4,
      IID_MODEM   = 3'd5,
      IID_FLOW    = 3'd6
   } iid_e;

   localparam int NUM_EN   = 5;
   localparam int EN_RX    = 0;
   localparam int EN_TX    = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;
   localparam int EN_FLOW  = 4;

   // priority levels, index 0 is the most urgent
   localparam int LVL_LINE  = 0;
   localparam int LVL_RX    = 1;
   localparam int LVL_TX    = 2;
   localparam int LVL_MODEM = 3;
   localparam int LVL_FLOW  = 4;

   // longest frame in half bits: start + 8 data + parity + 2 stop
   localparam int MAX_HALF_BITS = 24;
endpackage

// File: rtl/rxto_frame_limit.sv
module rxto_frame_limit #(
   parameter int TICKS_PER_BIT = 16,
   parameter int TOUT_CHARS    = 4,
   parameter int TMR_W         = 10
) (
   input  logic [1:0]       wlen_sel,
   input  logic             parity_en,
   input  logic             stop_long,
   output logic [TMR_W-1:0] limit
);
   localparam int HALF_TICKS = TICKS_PER_BIT / 2;

   generate
      if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be even and at least 2");
      end
      if (TOUT_CHARS < 1) begin : g_bad_chars
         $error("TOUT_CHARS must be at least 1");
      end
   endgenerate

   // frame length in half bit times, so 1.5 stop bits stays integral
   always_comb begin
      int hb;
      hb = 2 * (6 + int'(wlen_sel) + int'(parity_en));
      if (!stop_long)
         hb = hb + 2;
      else if (wlen_sel == 2'd0)
         hb = hb + 3;
      else
         hb = hb + 4;
      limit = TMR_W'(hb * HALF_TICKS * TOUT_CHARS);
   end
endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
   parameter int CNT_W = 6,
   parameter int TMR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             stop_mid,
   input  logic             rhr_rd,
   input  logic [CNT_W-1:0] fifo_cnt,
   input  logic [TMR_W-1:0] limit,
   output logic             tout
);
   logic [TMR_W-1:0] idle_cnt;
   logic             fifo_has;
   logic             restart;
   logic             hit;

   assign fifo_has = |fifo_cnt;
   assign restart  = stop_mid | rhr_rd | ~fifo_has;
   // >= keeps a shortened format from letting the count run past the end
   assign hit      = baud_tick & ~restart & ~tout & (idle_cnt >= (limit - TMR_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_cnt <= '0;
      else if (restart || hit)
         idle_cnt <= '0;
      else if (baud_tick && !tout)
         idle_cnt <= idle_cnt + TMR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tout <= 1'b0;
      else if (rhr_rd)
         tout <= 1'b0;
      else if (hit)
         tout <= 1'b1;
   end

   p_no_tout_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tout) |-> $past(fifo_cnt != '0));

   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mid || rhr_rd) |=> (idle_cnt == '0));

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd |=> !tout);
endmodule

// File: rtl/rxto_irq_prio.sv
module rxto_irq_prio
   import rxto_pkg::*;
#(
   parameter bit FLOW_IRQ_EN = 1'b1,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EN-1:0] ien,
   input  logic              line_evt,
   input  logic              rx_ready,
   input  logic              tout,
   input  logic              tx_empty,
   input  logic              thr_wr,
   input  logic              iid_rd,
   input  logic              modem_evt,
   input  logic              flow_evt,
   output logic              irq,
   output logic [2:0]        iid
);
   localparam int NLVL = FLOW_IRQ_EN ? 5 : 4;

   logic            thre_pend;
   logic            tx_empty_q;
   logic [NLVL-1:0] pend;
   logic [2:0]      nxt_iid;
   logic            nxt_irq;

   // transmit-empty cause: armed from reset, consumed by a read or a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_pend  <= 1'b1;
         tx_empty_q <= 1'b0;
      end else begin
         tx_empty_q <= tx_empty;
         if (thr_wr || (iid_rd && iid == IID_TXEMPTY))
            thre_pend <= 1'b0;
         else if (tx_empty && !tx_empty_q)
            thre_pend <= 1'b1;
      end
   end

   assign pend[LVL_LINE]  = ien[EN_LINE]  & line_evt;
   assign pend[LVL_RX]    = ien[EN_RX]    & (rx_ready | tout);
   assign pend[LVL_TX]    = ien[EN_TX]    & tx_empty & thre_pend;
   assign pend[LVL_MODEM] = ien[EN_MODEM] & modem_evt;

   generate
      if (FLOW_IRQ_EN) begin : g_flow
         assign pend[LVL_FLOW] = ien[EN_FLOW] & flow_evt;
      end else begin : g_noflow
         logic unused_flow;
         assign unused_flow = ien[EN_FLOW] ^ flow_evt;
      end
   endgenerate

   always_comb begin
      int sel;
      sel = -1;
      for (int i = NLVL - 1; i >= 0; i--) begin
         if (pend[i]) sel = i;
      end
      case (sel)
         LVL_LINE:  nxt_iid = IID_LINE;
         LVL_RX:    nxt_iid = tout ? IID_RXTOUT : IID_RXDATA;
         LVL_TX:    nxt_iid = IID_TXEMPTY;
         LVL_MODEM: nxt_iid = IID_MODEM;
         LVL_FLOW:  nxt_iid = IID_FLOW;
         default:   nxt_iid = IID_NONE;
      endcase
      nxt_irq = |pend;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               iid <= IID_NONE;
               irq <= 1'b0;
            end else begin
               iid <= nxt_iid;
               irq <= nxt_irq;
            end
         end
      end else begin : g_comb
         assign iid = nxt_iid;
         assign irq = nxt_irq;
      end
   endgenerate

   p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (iid != IID_NONE));

   p_thr_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre_pend);
endmodule

// File: rtl/rx_timeout_irq.sv
module rx_timeout_irq
   import rxto_pkg::*;
#(
   parameter int FIFO_DEPTH    = 32,
   parameter int TICKS_PER_BIT = 16,
   parameter int TOUT_CHARS    = 4,
   parameter bit FLOW_IRQ_EN   = 1'b1,
   parameter bit REG_OUT       = 1'b0,
   localparam int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic [1:0]       wlen_sel,
   input  logic             parity_en,
   input  logic             stop_long,
   input  logic             stop_mid,
   input  logic             rhr_rd,
   input  logic [CNT_W-1:0] fifo_cnt,
   input  logic [CNT_W-1:0] rx_trig,
   input  logic [4:0]       ien,
   input  logic             tx_empty,
   input  logic             thr_wr,
   input  logic             iid_rd,
   input  logic             line_evt,
   input  logic             modem_evt,
   input  logic             flow_evt,
   output logic             tout,
   output logic             irq,
   output logic [2:0]       iid
);
   localparam int MAX_LIMIT = TOUT_CHARS * (TICKS_PER_BIT / 2) * MAX_HALF_BITS;
   localparam int TMR_W     = $clog2(MAX_LIMIT + 1);

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
   endgenerate

   logic [TMR_W-1:0] limit;
   logic             rx_ready;

   assign rx_ready = (fifo_cnt != '0) && (fifo_cnt >= rx_trig);

   rxto_frame_limit #(
      .TICKS_PER_BIT(TICKS_PER_BIT),
      .TOUT_CHARS   (TOUT_CHARS),
      .TMR_W        (TMR_W)
   ) u_limit (
      .wlen_sel (wlen_sel),
      .parity_en(parity_en),
      .stop_long(stop_long),
      .limit    (limit)
   );

   rxto_idle_timer #(
      .CNT_W(CNT_W),
      .TMR_W(TMR_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .baud_tick(baud_tick),
      .stop_mid (stop_mid),
      .rhr_rd   (rhr_rd),
      .fifo_cnt (fifo_cnt),
      .limit    (limit),
      .tout     (tout)
   );

   rxto_irq_prio #(
      .FLOW_IRQ_EN(FLOW_IRQ_EN),
      .REG_OUT    (REG_OUT)
   ) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .ien      (ien),
      .line_evt (line_evt),
      .rx_ready (rx_ready),
      .tout     (tout),
      .tx_empty (tx_empty),
      .thr_wr   (thr_wr),
      .iid_rd   (iid_rd),
      .modem_evt(modem_evt),
      .flow_evt (flow_evt),
      .irq      (irq),
      .iid      (iid)
   );
endmodule

// File: tb/tb_rx_timeout_irq.sv
`timescale 1ns/1ps
module tb_rx_timeout_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [1:0] wlen_sel = 2'd3;
   logic       parity_en = 1'b0;
   logic       stop_long = 1'b0;
   logic       stop_mid = 1'b0;
   logic       rhr_rd = 1'b0;
   logic [5:0] fifo_cnt = 6'd0;
   logic [5:0] rx_trig = 6'd4;
   logic [4:0] ien = 5'b00010;
   logic       tx_empty = 1'b1;
   logic       thr_wr = 1'b0;
   logic       iid_rd = 1'b0;
   logic       line_evt = 1'b0;
   logic       modem_evt = 1'b0;
   logic       flow_evt = 1'b0;
   logic       tout;
   logic       irq;
   logic [2:0] iid;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rx_timeout_irq dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wlen_sel(wlen_sel),
      .parity_en(parity_en), .stop_long(stop_long), .stop_mid(stop_mid),
      .rhr_rd(rhr_rd), .fifo_cnt(fifo_cnt), .rx_trig(rx_trig), .ien(ien),
      .tx_empty(tx_empty), .thr_wr(thr_wr), .iid_rd(iid_rd),
      .line_evt(line_evt), .modem_evt(modem_evt), .flow_evt(flow_evt),
      .tout(tout), .irq(irq), .iid(iid)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // period in 16x ticks, straight from the frame description
   function automatic int period(input int wl, input int par, input int sl);
      int stop16;
      if (sl == 0) stop16 = 16;
      else if (wl == 0) stop16 = 24;
      else stop16 = 32;
      return 4 * (16 * (1 + (5 + wl) + par) + stop16);
   endfunction

   // {ien[4:0], line, fifo_cnt[5:0], modem, flow, expected iid} with rx_trig=4
   localparam logic [16:0] VEC [11] = '{
      {5'b11111, 1'b1, 6'd5, 1'b1, 1'b1, 3'd1},
      {5'b11111, 1'b0, 6'd5, 1'b1, 1'b1, 3'd2},
      {5'b11111, 1'b0, 6'd3, 1'b1, 1'b1, 3'd5},
      {5'b11111, 1'b0, 6'd3, 1'b0, 1'b1, 3'd6},
      {5'b11111, 1'b0, 6'd4, 1'b0, 1'b0, 3'd2},
      {5'b00000, 1'b1, 6'd9, 1'b1, 1'b1, 3'd0},
      {5'b11110, 1'b0, 6'd8, 1'b1, 1'b0, 3'd5},
      {5'b01111, 1'b0, 6'd0, 1'b0, 1'b1, 3'd0},
      {5'b11011, 1'b1, 6'd0, 1'b0, 1'b1, 3'd6},
      {5'b10000, 1'b0, 6'd0, 1'b0, 1'b1, 3'd6},
      {5'b11111, 1'b0, 6'd0, 1'b0, 1'b0, 3'd0}
   };

   task automatic read_rhr();
      @(negedge clk) rhr_rd = 1'b1;
      @(negedge clk) rhr_rd = 1'b0;
   endtask

   task automatic edge_probe(input string req, input int len);
      repeat (len - 1) @(negedge clk);
      check(req, tout, 0);
      @(negedge clk);
      check(req, tout, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: transmit-empty pending straight out of reset
      check("R8 iid after reset", iid, 4);
      check("R8 irq after reset", irq, 1);
      check("R1 tout after reset", tout, 0);

      // R9: identifier read while tx-empty reported clears it
      @(negedge clk) iid_rd = 1'b1;
      @(negedge clk) iid_rd = 1'b0;
      check("R9 clear by iid read", iid, 0);
      tx_empty = 1'b0;
      @(negedge clk) tx_empty = 1'b1;
      @(negedge clk);
      check("R9 re-raise on tx_empty rise", iid, 4);
      @(negedge clk) thr_wr = 1'b1;
      @(negedge clk) thr_wr = 1'b0;
      check("R9 clear by thr write", iid, 0);
      tx_empty = 1'b0;

      // R6 R7 R10 R5: priority vectors
      for (int k = 0; k < 11; k++) begin
         @(negedge clk);
         ien       = VEC[k][16:12];
         line_evt  = VEC[k][11];
         fifo_cnt  = VEC[k][10:5];
         modem_evt = VEC[k][4];
         flow_evt  = VEC[k][3];
         #1;
         check($sformatf("R6/R10 vector %0d iid", k), iid, int'(VEC[k][2:0]));
         check($sformatf("R7 vector %0d irq", k), irq, int'(VEC[k][2:0] != 3'd0));
      end

      // R1: empty FIFO never times out
      ien = 5'b00001; line_evt = 0; modem_evt = 0; flow_evt = 0;
      fifo_cnt = 6'd0; baud_tick = 1'b1;
      repeat (1000) @(negedge clk);
      check("R1 no tout when empty", tout, 0);

      // R3: exact edge for 8N1
      fifo_cnt = 6'd1;
      read_rhr();
      edge_probe("R3 8N1 edge", period(3, 0, 0));
      // R5: time-out code on the shared level
      check("R5 tout code", iid, 3);
      fifo_cnt = 6'd5;
      #1 check("R5 tout over data", iid, 3);
      // R4: read clears the flag, data-ready shows
      read_rhr();
      check("R4 tout cleared by read", tout, 0);
      check("R5 data code", iid, 2);
      fifo_cnt = 6'd1;

      // R3: 5 bits with 1.5 stop
      wlen_sel = 2'd0; stop_long = 1'b1;
      read_rhr();
      edge_probe("R3 5-bit 1.5 stop edge", period(0, 0, 1));

      // R3: 7 bits, parity, 2 stop
      wlen_sel = 2'd2; parity_en = 1'b1;
      read_rhr();
      edge_probe("R3 7-bit parity 2 stop edge", period(2, 1, 1));

      // R2: stop-centre strobe restarts the count
      wlen_sel = 2'd3; parity_en = 1'b0; stop_long = 1'b0;
      read_rhr();
      repeat (100) @(negedge clk);
      stop_mid = 1'b1;
      @(negedge clk) stop_mid = 1'b0;
      edge_probe("R2 restart by stop centre", period(3, 0, 0));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule